// File: doc/BRIEF.md
# Ingress Timestamp Capture Unit

This block puts a receive timestamp on every frame that leaves a streaming receive path toward the client. On the line side it watches the incoming beats. On the first beat of each frame it stores the free-running 96-bit time-of-day value present in that cycle. The frame beats then pass through a receive pipeline whose latency is a fixed parameter. The stored time value waits in a small queue and is placed on the timestamp output in the same cycle as that frame's client-side start-of-packet beat.

The timestamp therefore records when the frame arrived on the link, not the time at which the client sees it. Every frame gets one, whatever its contents. The output needs no acknowledge: client logic may read it or ignore it. Between start-of-packet beats the output keeps its last value. If the queue is full when a frame starts, the stamp for that frame is dropped and a sticky error flag is raised.

Top module: `ing_ts_capture`

## Requirements
- R1: Each line-side start beat (`ln_valid`=1 and `ln_sop`=1) produces exactly one client start beat, and while no overflow has occurred, every client start beat carries a timestamp.
- R2: The client stream (`cl_valid`, `cl_sop`, `cl_eop`, `cl_data`) equals the line stream delayed by exactly LAT clock cycles.
- R3: On a stamped client start beat, `cl_ts` equals the `tod_in` value that was present in the cycle of that frame's line-side start beat, LAT cycles earlier.
- R4: In every cycle without a stamped client start beat, `cl_ts` holds the value it had in the previous cycle.
- R5: The time value is carried bit-exact in its field layout: seconds in bits [95:48], nanoseconds in bits [47:16], fractional nanoseconds in bits [15:0].
- R6: Up to DEPTH timestamps may be pending between line-side and client-side start beats without any loss and without raising `ovf_err`.
- R7: A line-side start beat that arrives while DEPTH stamps are pending, with no client start beat in the same cycle, sets `ovf_err` from the next cycle until reset. Its stamp is dropped, and on that frame's client start beat `cl_ts` keeps its previous value.
- R8: When a line-side start beat and a stamped client start beat fall in the same cycle with DEPTH stamps pending, the new stamp is accepted and `ovf_err` does not rise.
- R9: While reset is asserted, `cl_valid` and `ovf_err` are 0, `cl_ts` is all zeros, and all pending stamps are discarded.
- R10: A beat with `ln_valid`=0 captures no timestamp, whatever the value of `ln_sop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both stream sides |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| tod_in | input | 96 | Free-running time of day: seconds, nanoseconds, fraction |
| ln_valid | input | 1 | Line-side beat valid |
| ln_sop | input | 1 | Line-side first beat of a frame |
| ln_eop | input | 1 | Line-side last beat of a frame |
| ln_data | input | DW | Line-side beat data |
| cl_valid | output | 1 | Client-side beat valid |
| cl_sop | output | 1 | Client-side first beat of a frame |
| cl_eop | output | 1 | Client-side last beat of a frame |
| cl_data | output | DW | Client-side beat data |
| cl_ts | output | 96 | Arrival timestamp, valid on client start beats |
| ovf_err | output | 1 | Sticky flag: a stamp was dropped because the queue was full |

## Verification
A push of a new stamp at a line-side start and a pop of the oldest stamp at a client start can fall in the same cycle, and this matters most when the queue is full. A directed case provokes it with one start beat, four idle beats and then four back-to-back single-beat frames, so that the fourth of these arrives exactly as the first one leaves. The check passes if the flag stays low and every later stamp still matches. Random single-beat bursts create many more such collisions, including true overflows. Each of these is judged against a bench model of occupancy, drops and held output values.

// File: rtl/ing_ts_pkg.sv
package ing_ts_pkg;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 32;
  localparam int FRAC_W = 16;
  localparam int TOD_W  = SEC_W + NS_W + FRAC_W;

  typedef logic [TOD_W-1:0] tod_t;
endpackage

// File: rtl/ing_ts_delay.sv
// Fixed-latency receive pipeline; carries the beat plus a "stamp queued" flag.
module ing_ts_delay #(
  parameter int DW  = 64,
  parameter int LAT = 8   // at least 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          in_ok,
  input  logic [DW-1:0] in_dat,
  output logic          out_vld,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_ok,
  output logic [DW-1:0] out_dat
);
  logic          vld_q [LAT];
  logic          sop_q [LAT];
  logic          eop_q [LAT];
  logic          ok_q  [LAT];
  logic [DW-1:0] dat_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stg
    logic          vld_d, sop_d, eop_d, ok_d;
    logic [DW-1:0] dat_d;

    if (i == 0) begin : g_head
      assign vld_d = in_vld;
      assign sop_d = in_sop;
      assign eop_d = in_eop;
      assign ok_d  = in_ok;
      assign dat_d = in_dat;
    end else begin : g_tail
      assign vld_d = vld_q[i-1];
      assign sop_d = sop_q[i-1];
      assign eop_d = eop_q[i-1];
      assign ok_d  = ok_q[i-1];
      assign dat_d = dat_q[i-1];
    end

    // control flags: reset, loaded only with a valid beat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        sop_q[i] <= 1'b0;
        eop_q[i] <= 1'b0;
        ok_q[i]  <= 1'b0;
      end else begin
        vld_q[i] <= vld_d;
        if (vld_d) begin
          sop_q[i] <= sop_d;
          eop_q[i] <= eop_d;
          ok_q[i]  <= ok_d;
        end
      end
    end

    // payload: no reset, clock-enabled by valid
    always_ff @(posedge clk) begin
      if (vld_d) dat_q[i] <= dat_d;
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_sop = sop_q[LAT-1];
  assign out_eop = eop_q[LAT-1];
  assign out_ok  = ok_q[LAT-1];
  assign out_dat = dat_q[LAT-1];
endmodule

// File: rtl/ing_ts_fifo.sv
// Queue of pending arrival stamps.
module ing_ts_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? ptr_inc(wp_q) : wp_q;
    rp_d  = pop  ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_push_has_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/ing_ts_capture.sv
module ing_ts_capture
  import ing_ts_pkg::*;
#(
  parameter int DW    = 64,
  parameter int LAT   = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOD_W-1:0] tod_in,
  input  logic             ln_valid,
  input  logic             ln_sop,
  input  logic             ln_eop,
  input  logic [DW-1:0]    ln_data,
  output logic             cl_valid,
  output logic             cl_sop,
  output logic             cl_eop,
  output logic [DW-1:0]    cl_data,
  output logic [TOD_W-1:0] cl_ts,
  output logic             ovf_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic sop_det, push, pop, q_full, q_empty, out_ok;
  tod_t head, last_q, last_d;
  logic ovf_d;

  assign sop_det = ln_valid & ln_sop;               // line-side frame start
  assign pop     = cl_valid & cl_sop & out_ok;      // client start with a queued stamp
  assign push    = sop_det & (~q_full | pop);

  ing_ts_delay #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_vld  (ln_valid),
    .in_sop  (ln_sop),
    .in_eop  (ln_eop),
    .in_ok   (push),
    .in_dat  (ln_data),
    .out_vld (cl_valid),
    .out_sop (cl_sop),
    .out_eop (cl_eop),
    .out_ok  (out_ok),
    .out_dat (cl_data)
  );

  ing_ts_fifo #(.W(TOD_W), .DEPTH(DEPTH)) u_stamps (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (push),
    .pop   (pop),
    .wdata (tod_in),
    .rdata (head),
    .full  (q_full),
    .empty (q_empty)
  );

  always_comb begin
    last_d = pop ? head : last_q;
    ovf_d  = ovf_err | (sop_det & q_full & ~pop);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      last_q  <= '0;
      ovf_err <= 1'b0;
    end else begin
      last_q  <= last_d;
      ovf_err <= ovf_d;
    end
  end

  assign cl_ts = pop ? head : last_q;

  assert_every_sop_stamped_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cl_valid && cl_sop && !ovf_err) |-> out_ok);
  assert_pop_has_entry_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    pop |-> !q_empty);
  assert_ts_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> (pop || $stable(cl_ts)));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ovf_err |=> ovf_err);
  assert_ovf_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sop_det && q_full && !pop) |=> ovf_err);
  assert_swap_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ovf_err && sop_det && q_full && pop) |=> !ovf_err);
endmodule

// File: tb/ing_ts_capture_test.sv
module ing_ts_capture_test;
  localparam int DW    = 64;
  localparam int LAT   = 8;
  localparam int DEPTH = 4;
  localparam int HN    = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n;
  logic [95:0]   tod_in;
  logic          ln_valid, ln_sop, ln_eop;
  logic [DW-1:0] ln_data;
  logic          cl_valid, cl_sop, cl_eop, ovf_err;
  logic [DW-1:0] cl_data;
  logic [95:0]   cl_ts;

  ing_ts_capture #(.DW(DW), .LAT(LAT), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .tod_in(tod_in),
    .ln_valid(ln_valid), .ln_sop(ln_sop), .ln_eop(ln_eop), .ln_data(ln_data),
    .cl_valid(cl_valid), .cl_sop(cl_sop), .cl_eop(cl_eop), .cl_data(cl_data),
    .cl_ts(cl_ts), .ovf_err(ovf_err)
  );

  int total = 0;
  int bad   = 0;

  // bench model state
  bit            hv [HN];
  bit            hs [HN];
  bit            he [HN];
  bit            hok[HN];
  logic [DW-1:0] hd [HN];
  logic [95:0]   ht [HN];
  int            k, m_cnt, line_sops, cl_sops, rem;
  bit            m_err, inf;
  logic [95:0]   m_last, tod_cur;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] next_tod(input logic [95:0] t);
    logic [47:0] sec;
    logic [31:0] ns;
    logic [15:0] fr;
    sec = t[95:48];
    ns  = t[47:16] + 32'd8;
    fr  = t[15:0] + 16'h1357;
    if (ns >= 32'd1_000_000_000) begin
      ns  = ns - 32'd1_000_000_000;
      sec = sec + 48'd1;
    end
    return {sec, ns, fr};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < HN; i++) begin
      hv[i] = 0; hs[i] = 0; he[i] = 0; hok[i] = 0; hd[i] = '0; ht[i] = '0;
    end
    k = 0; m_cnt = 0; m_err = 0; m_last = '0;
  endtask

  task automatic step(input bit v, input bit s, input bit e, input logic [DW-1:0] d);
    int o;
    bit pop_e, sd, ok;
    @(negedge clk);
    o = (k + HN - LAT) % HN;
    pop_e = hv[o] && hs[o] && hok[o];
    chk(cl_valid == hv[o], "R2 client valid", 96'(cl_valid), 96'(hv[o]));
    if (hv[o])
      chk(cl_sop == hs[o] && cl_eop == he[o] && cl_data == hd[o], "R2 client beat",
          96'({cl_sop, cl_eop, cl_data}), 96'({hs[o], he[o], hd[o]}));
    if (pop_e) begin
      chk(cl_ts == ht[o], "R1 R3 arrival stamp", cl_ts, ht[o]);
      chk(cl_ts[95:48] == ht[o][95:48], "R5 seconds field", 96'(cl_ts[95:48]), 96'(ht[o][95:48]));
      m_last = ht[o];
    end else if (hv[o] && hs[o]) begin
      chk(cl_ts == m_last, "R7 dropped stamp keeps value", cl_ts, m_last);
    end else begin
      chk(cl_ts == m_last, "R4 hold outside start", cl_ts, m_last);
    end
    chk(ovf_err == m_err, "R7 error flag", 96'(ovf_err), 96'(m_err));
    if (cl_valid && cl_sop) cl_sops++;
    // drive this cycle
    ln_valid = v; ln_sop = s; ln_eop = e; ln_data = d; tod_in = tod_cur;
    sd = v && s;
    ok = sd && (m_cnt < DEPTH || pop_e);
    if (sd && !ok) m_err = 1;
    if (sd) line_sops++;
    m_cnt = m_cnt - int'(pop_e) + int'(ok);
    hv[k % HN] = v; hs[k % HN] = s; he[k % HN] = e; hok[k % HN] = ok;
    hd[k % HN] = d; ht[k % HN] = tod_cur;
    k++;
    tod_cur = next_tod(tod_cur);
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom, $urandom};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ln_valid = 0; ln_sop = 0; ln_eop = 0; ln_data = '0;
    repeat (3) @(negedge clk);
    chk(cl_valid == 0, "R9 valid cleared", 96'(cl_valid), 96'd0);
    chk(ovf_err == 0, "R9 error cleared", 96'(ovf_err), 96'd0);
    chk(cl_ts == '0, "R9 stamp cleared", cl_ts, 96'd0);
    rst_n = 1;
    model_clear();
    idle(4);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd914));
    rst_n = 0; ln_valid = 0; ln_sop = 0; ln_eop = 0; ln_data = '0;
    tod_cur = {48'd5, 32'd999_999_000, 16'h00a5};
    tod_in = tod_cur;
    line_sops = 0; cl_sops = 0; inf = 0; rem = 0;
    do_reset();

    // R10: start flag without valid, then DEPTH real frames in flight (R6)
    step(0, 1, 0, rnd_data());
    for (int i = 0; i < DEPTH; i++) step(1, 1, 1, rnd_data());
    idle(LAT + 3);
    chk(ovf_err == 0, "R6 R10 no overflow", 96'(ovf_err), 96'd0);

    // R8: fourth queued start coincides with the first client start
    step(1, 1, 1, rnd_data());
    idle(4);
    for (int i = 0; i < 4; i++) step(1, 1, 1, rnd_data());
    idle(LAT + 3);
    chk(ovf_err == 0, "R8 push and pop together", 96'(ovf_err), 96'd0);

    // R7: DEPTH+1 back-to-back starts
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 1, rnd_data());
    idle(LAT + 3);
    chk(ovf_err == 1, "R7 overflow flagged", 96'(ovf_err), 96'd1);

    // random traffic
    do_reset();
    line_sops = 0; cl_sops = 0; inf = 0;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 2 && !inf) begin
        step(0, bit'($urandom % 2), bit'($urandom % 2), rnd_data());
      end else if (!inf) begin
        int len;
        len = ($urandom % 3 == 0) ? 1 + int'($urandom % 6) : 1;
        step(1, 1, len == 1, rnd_data());
        rem = len - 1;
        inf = (rem != 0);
      end else begin
        rem--;
        step(1, 0, rem == 0, rnd_data());
        inf = (rem != 0);
      end
    end
    idle(LAT + 3);
    chk(cl_sops == line_sops, "R1 one client start per frame", 96'(cl_sops), 96'(line_sops));

    do_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule